// File: doc/BRIEF.md
# SCSI Data-In Receiver with Odd Parity Check

This block brings a programmed number of bytes in from the SCSI data lines. It drives the request line (active low) and watches the acknowledge line (active low). The acknowledge line passes through a synchronizer before the block uses it. Two pacing modes are available. In interlocked mode, every byte takes a full request/acknowledge exchange. In paced mode, the block sends out a train of request pulses on its own timer and never waits for acknowledge between them. In paced mode, each synchronized falling edge of acknowledge captures one byte.

Every captured byte is nine bits: eight data bits and one parity bit. The nine bits must hold an odd number of ones. If they do, the eight data bits go into a small buffer, and the buffer drains through a ready/valid output. If they do not, the byte is dropped, the transfer stops at once and a sticky interrupt flag is set. The flag stays set until it is cleared from outside. While the flag is set, the block will not start a new transfer.

Before each request, the block reserves a slot in its buffer. A stalled consumer therefore holds off further request activity, and no byte is ever lost.

Top module: `scsi_rx_engine`

## Requirements
- R1: After reset, `req_n_o` is high, `out_valid_o` is low and `irq_o` is low.
- R2: In interlocked mode (`mode_sync_i` = 0 at start), the block pulls `req_n_o` low only while the synchronized acknowledge is high. It raises `req_n_o` and captures the byte once the synchronized acknowledge is seen low. It makes exactly one request per byte.
- R3: A start loads `count_m1_i`, and the transfer moves exactly `count_m1_i`+1 bytes. After that, `req_n_o` stays high.
- R4: In paced mode (`mode_sync_i` = 1), each request pulse holds `req_n_o` low for `req_width_i` cycles (1 or more). Consecutive pulses start `req_period_i` cycles apart whenever a buffer slot is free. No pulse waits for acknowledge.
- R5: In paced mode, a byte is captured on each synchronized falling edge of acknowledge that matches an outstanding request. An acknowledge edge with no outstanding request is ignored and produces no output.
- R6: Odd parity: a byte whose nine bits (`db_i`, `dbp_i`) hold an odd number of ones appears on `out_data_o`, in arrival order.
- R7: A byte with even parity is not output. It sets `irq_o`, and `req_n_o` stays high from then on until a new transfer starts.
- R8: `irq_o` stays set until `irq_clr_i` is pulsed. A start while `irq_o` is set is ignored.
- R9: Outstanding requests plus buffered bytes never exceed DEPTH (4). With `out_ready_i` low, no more than DEPTH requests are made.
- R10: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o` stays high and `out_data_o` does not change.
- R11: A start that arrives while a transfer is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a transfer (single-cycle pulse) |
| mode_sync_i | input | 1 | 1 selects paced mode, 0 selects interlocked mode; sampled at start |
| count_m1_i | input | CNT_W | Bytes to move minus one; sampled at start |
| req_width_i | input | TIM_W | Request low time in paced mode, in cycles |
| req_period_i | input | TIM_W | Spacing between request pulses in paced mode, in cycles |
| db_i | input | DW | Bus data lines |
| dbp_i | input | 1 | Bus parity line |
| req_n_o | output | 1 | Request, active low |
| ack_n_i | input | 1 | Acknowledge, active low, asynchronous |
| out_data_o | output | DW | Output byte |
| out_valid_o | output | 1 | Output byte valid |
| out_ready_i | input | 1 | Consumer ready |
| irq_o | output | 1 | Sticky parity error flag |
| irq_clr_i | input | 1 | Clear the parity error flag |

## Verification
The assertions check several rules on every cycle:
- the slot reservation bound;
- the output holding steady while stalled;
- the interrupt flag staying set;
- the request line being quiet while idle or in error;
- the rule that an interlocked request only follows a high acknowledge.

Other properties need a peer model, so only the directed scenarios can show them:
- exact byte counts;
- pulse widths and spacing in paced mode;
- the data order;
- the rejection of stray acknowledge edges;
- ignored starts;
- the stop after a bad byte.

// File: rtl/scsi_rx_pkg.sv
package scsi_rx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_A_WAIT_HI = 2'd1,
        ST_A_WAIT_LO = 2'd2,
        ST_S_RUN     = 2'd3
    } rx_state_e;

endpackage

// File: rtl/scsi_rx_ack_sync.sv
module scsi_rx_ack_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_n_i,
    output logic ack_level_o,
    output logic ack_fall_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (STAGES == 1) begin
            s_d.chain[0] = ack_n_i;
        end else begin
            s_d.chain = {s_q.chain[STAGES-2:0], ack_n_i};
        end
        s_d.prev = s_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{chain: '1, prev: 1'b1};
        end else begin
            s_q <= s_d;
        end
    end

    assign ack_level_o = s_q.chain[STAGES-1];
    assign ack_fall_o  = s_q.prev & ~s_q.chain[STAGES-1];
endmodule

// File: rtl/scsi_rx_parity.sv
module scsi_rx_parity #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] data_i,
    input  logic          par_i,
    output logic          ok_o
);
    logic [DW:0] bits;

    always_comb begin
        bits = {par_i, data_i};
        ok_o = ^bits;
    end
endmodule

// File: rtl/scsi_rx_fifo.sv
module scsi_rx_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push_i,
    input  logic [DW-1:0]                din_i,
    output logic [DW-1:0]                dout_o,
    output logic                         valid_o,
    input  logic                         ready_i,
    output logic [$clog2(DEPTH+1)-1:0]   count_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
        logic [CW-1:0] count;
    } fifo_t;

    fifo_t f_d, f_q;
    logic [DW-1:0] mem [DEPTH];
    logic do_push, do_pop;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        f_d     = f_q;
        do_pop  = (f_q.count != '0) && ready_i;
        do_push = push_i && (f_q.count != CW'(DEPTH));
        if (do_push) f_d.wr = bump(f_q.wr);
        if (do_pop)  f_d.rd = bump(f_q.rd);
        f_d.count = f_q.count + CW'(do_push) - CW'(do_pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[f_q.wr] <= din_i;
    end

    assign dout_o  = mem[f_q.rd];
    assign valid_o = (f_q.count != '0);
    assign count_o = f_q.count;
endmodule

// File: rtl/scsi_rx_engine.sv
module scsi_rx_engine
    import scsi_rx_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int TIM_W       = 8,
    parameter int DEPTH       = 4,
    parameter int SYNC_STAGES = 2,
    parameter int DW          = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             mode_sync_i,
    input  logic [CNT_W-1:0] count_m1_i,
    input  logic [TIM_W-1:0] req_width_i,
    input  logic [TIM_W-1:0] req_period_i,
    input  logic [DW-1:0]    db_i,
    input  logic             dbp_i,
    output logic             req_n_o,
    input  logic             ack_n_i,
    output logic [DW-1:0]    out_data_o,
    output logic             out_valid_o,
    input  logic             out_ready_i,
    output logic             irq_o,
    input  logic             irq_clr_i
);
    localparam int OCC_W  = $clog2(DEPTH + 1);
    localparam int LEFT_W = CNT_W + 1;

    typedef struct packed {
        rx_state_e         state;
        logic              sync_mode;
        logic [LEFT_W-1:0] bytes_left;
        logic [LEFT_W-1:0] req_left;
        logic [OCC_W-1:0]  outstanding;
        logic [TIM_W-1:0]  timer;
        logic              pulse;
        logic              req_n;
        logic              irq;
    } regs_t;

    localparam regs_t REGS_RST = '{
        state:       ST_IDLE,
        sync_mode:   1'b0,
        bytes_left:  '0,
        req_left:    '0,
        outstanding: '0,
        timer:       '0,
        pulse:       1'b0,
        req_n:       1'b1,
        irq:         1'b0
    };

    regs_t r_d, r_q;

    logic             ack_level, ack_fall;
    logic             par_ok;
    logic [OCC_W-1:0] fifo_count;
    logic [OCC_W:0]   reserved;
    logic             slot_free;
    logic             issue, capture, halt, push;
    logic [TIM_W-1:0] width_ld, gap_ld;
    logic             in_idle, sync_mode_q;

    scsi_rx_ack_sync #(.STAGES(SYNC_STAGES)) u_ack (
        .clk        (clk),
        .rst_n      (rst_n),
        .ack_n_i    (ack_n_i),
        .ack_level_o(ack_level),
        .ack_fall_o (ack_fall)
    );

    scsi_rx_parity #(.DW(DW)) u_par (
        .data_i(db_i),
        .par_i (dbp_i),
        .ok_o  (par_ok)
    );

    scsi_rx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .push_i (push),
        .din_i  (db_i),
        .dout_o (out_data_o),
        .valid_o(out_valid_o),
        .ready_i(out_ready_i),
        .count_o(fifo_count)
    );

    assign reserved  = {1'b0, r_q.outstanding} + {1'b0, fifo_count};
    assign slot_free = reserved < (OCC_W + 1)'(DEPTH);
    assign width_ld  = (req_width_i == '0) ? '0 : req_width_i - 1'b1;
    assign gap_ld    = (req_period_i > req_width_i) ? (req_period_i - req_width_i - 1'b1) : '0;

    always_comb begin
        r_d     = r_q;
        issue   = 1'b0;
        capture = 1'b0;
        halt    = 1'b0;

        if (irq_clr_i) r_d.irq = 1'b0;

        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i && !r_q.irq) begin
                    r_d.sync_mode  = mode_sync_i;
                    r_d.bytes_left = {1'b0, count_m1_i} + 1'b1;
                    r_d.req_left   = {1'b0, count_m1_i} + 1'b1;
                    r_d.timer      = '0;
                    r_d.pulse      = 1'b0;
                    r_d.state      = mode_sync_i ? ST_S_RUN : ST_A_WAIT_HI;
                end
            end
            ST_A_WAIT_HI: begin
                if (ack_level && slot_free) begin
                    issue     = 1'b1;
                    r_d.req_n = 1'b0;
                    r_d.state = ST_A_WAIT_LO;
                end
            end
            ST_A_WAIT_LO: begin
                if (!ack_level) begin
                    capture   = 1'b1;
                    r_d.req_n = 1'b1;
                    r_d.state = ST_A_WAIT_HI;
                end
            end
            ST_S_RUN: begin
                capture = ack_fall && (r_q.outstanding != '0);
                if (r_q.pulse) begin
                    if (r_q.timer == '0) begin
                        r_d.pulse = 1'b0;
                        r_d.req_n = 1'b1;
                        r_d.timer = gap_ld;
                    end else begin
                        r_d.timer = r_q.timer - 1'b1;
                    end
                end else if (r_q.timer != '0) begin
                    r_d.timer = r_q.timer - 1'b1;
                end else if ((r_q.req_left != '0) && slot_free) begin
                    issue        = 1'b1;
                    r_d.pulse    = 1'b1;
                    r_d.req_n    = 1'b0;
                    r_d.timer    = width_ld;
                    r_d.req_left = r_q.req_left - 1'b1;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase

        r_d.outstanding = r_q.outstanding + OCC_W'(issue) - OCC_W'(capture);
        push = capture && par_ok;

        if (capture) begin
            if (!par_ok) begin
                r_d.irq = 1'b1;
                halt    = 1'b1;
            end else begin
                r_d.bytes_left = r_q.bytes_left - 1'b1;
                if (r_q.bytes_left == LEFT_W'(1)) halt = 1'b1;
            end
        end

        if (halt) begin
            r_d.state       = ST_IDLE;
            r_d.req_n       = 1'b1;
            r_d.pulse       = 1'b0;
            r_d.timer       = '0;
            r_d.outstanding = '0;
            r_d.req_left    = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= REGS_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_n_o     = r_q.req_n;
    assign irq_o       = r_q.irq;
    assign in_idle     = (r_q.state == ST_IDLE);
    assign sync_mode_q = r_q.sync_mode;
endmodule

// File: rtl/scsi_rx_engine_chk.sv
module scsi_rx_engine_chk #(
    parameter int DEPTH = 4,
    parameter int RW    = 4,
    parameter int DW    = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_n_o,
    input logic          out_valid_o,
    input logic          out_ready_i,
    input logic [DW-1:0] out_data_o,
    input logic          irq_o,
    input logic          irq_clr_i,
    input logic          ack_level,
    input logic          sync_mode_q,
    input logic          in_idle,
    input logic [RW-1:0] reserved
);
    AST_ASYNC_REQ_AFTER_ACK_HI: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(req_n_o) && !sync_mode_q) |-> $past(ack_level)); // R2

    AST_IDLE_REQ_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        in_idle |-> req_n_o); // R3

    AST_ERR_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (in_idle && req_n_o)); // R7

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !irq_clr_i) |=> irq_o); // R8

    AST_SLOT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        reserved <= RW'(DEPTH)); // R9

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o))); // R10
endmodule

bind scsi_rx_engine scsi_rx_engine_chk #(
    .DEPTH(DEPTH),
    .RW   (OCC_W + 1),
    .DW   (DW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_n_o    (req_n_o),
    .out_valid_o(out_valid_o),
    .out_ready_i(out_ready_i),
    .out_data_o (out_data_o),
    .irq_o      (irq_o),
    .irq_clr_i  (irq_clr_i),
    .ack_level  (ack_level),
    .sync_mode_q(sync_mode_q),
    .in_idle    (in_idle),
    .reserved   (reserved)
);

// File: tb/test_scsi_rx_engine.sv
`timescale 1ns/1ps
module test_scsi_rx_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        msync = 1'b0;
    logic [15:0] cnt_m1 = '0;
    logic [7:0]  wid_cfg = 8'd3;
    logic [7:0]  per_cfg = 8'd8;
    logic [7:0]  db = '0;
    logic        dbp = 1'b0;
    logic        req_n;
    logic        ack_n = 1'b1;
    logic [7:0]  odata;
    logic        ovalid;
    logic        rdy = 1'b1;
    logic        irq;
    logic        irq_clr = 1'b0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int nfall = 0;
    int nrx = 0;
    int ack_viol = 0;
    int lowlen = 0;
    bit done = 0;
    logic req_prev = 1'b1;
    int fall_cyc [256];
    int wid [256];
    logic [7:0] rxq [256];
    logic [7:0] vec [16];

    always #10 clk = ~clk;

    scsi_rx_engine i_scsi_rx_engine (
        .clk(clk), .rst_n(rst_n), .start_i(start), .mode_sync_i(msync),
        .count_m1_i(cnt_m1), .req_width_i(wid_cfg), .req_period_i(per_cfg),
        .db_i(db), .dbp_i(dbp), .req_n_o(req_n), .ack_n_i(ack_n),
        .out_data_o(odata), .out_valid_o(ovalid), .out_ready_i(rdy),
        .irq_o(irq), .irq_clr_i(irq_clr)
    );

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (req_prev && !req_n) begin
                fall_cyc[nfall % 256] = cyc;
                if (!msync && !ack_n) ack_viol++;
                nfall++;
                lowlen = 0;
            end
            if (!req_n) lowlen++;
            if (!req_prev && req_n && nfall > 0) wid[(nfall - 1) % 256] = lowlen;
            if (ovalid && rdy) begin
                rxq[nrx % 256] = odata;
                nrx++;
            end
        end
        req_prev = req_n;
        if (cyc > 150000 && !done) begin
            errors++;
            $display("FAIL R3 watchdog: cycles %0d expected below %0d", cyc, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic step(input int n = 1);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic fill(input int n, input int seed);
        for (int i = 0; i < n; i++) vec[i] = 8'(seed + i * 37 + (i << 4));
    endtask

    task automatic kick(input bit sm, input int n);
        msync  = sm;
        cnt_m1 = 16'(n - 1);
        start  = 1'b1;
        step();
        start  = 1'b0;
    endtask

    // Peer: serves byte i once the i-th request after base is seen; bad_idx gets even parity
    task automatic peer(input int n, input int base, input int bad_idx, input bit sm);
        for (int i = 0; i < n; i++) begin
            int t = 0;
            while (nfall <= base + i && t < 600) begin step(); t++; end
            if (t >= 600) return;
            db  = vec[i];
            dbp = (i == bad_idx) ? (^vec[i]) : (~^vec[i]);
            step();
            ack_n = 1'b0;
            if (sm) begin
                step(3);
                ack_n = 1'b1;
                step(3);
            end else begin
                t = 0;
                while (!req_n && t < 600) begin step(); t++; end
                step();
                ack_n = 1'b1;
            end
        end
    endtask

    task automatic t_reset();
        chk(req_n === 1'b1, "R1 req_n after reset", int'(req_n), 1);
        chk(ovalid === 1'b0, "R1 out_valid after reset", int'(ovalid), 0);
        chk(irq === 1'b0, "R1 irq after reset", int'(irq), 0);
    endtask

    task automatic t_async_basic();
        int b0 = nfall, r0 = nrx;
        fill(5, 8'h15);
        rdy = 1'b1;
        kick(1'b0, 5);
        fork
            peer(5, b0, -1, 1'b0);
            begin
                step(20);
                cnt_m1 = 16'd20;
                start = 1'b1;
                step();
                start = 1'b0;
            end
        join
        step(30);
        chk(nrx - r0 == 5, "R3 R11 async byte count", nrx - r0, 5);
        chk(nfall - b0 == 5, "R2 one request per byte", nfall - b0, 5);
        chk(ack_viol == 0, "R2 request while ack low", ack_viol, 0);
        chk(req_n === 1'b1, "R3 req high after last byte", int'(req_n), 1);
        for (int i = 0; i < 5; i++)
            chk(rxq[(r0 + i) % 256] == vec[i], "R6 async data", int'(rxq[(r0 + i) % 256]), int'(vec[i]));
    endtask

    task automatic t_sync_timing();
        int b0 = nfall, r0 = nrx;
        fill(6, 8'h81);
        wid_cfg = 8'd3;
        per_cfg = 8'd8;
        rdy = 1'b1;
        kick(1'b1, 6);
        peer(6, b0, -1, 1'b1);
        step(30);
        chk(nfall - b0 == 6, "R3 sync pulse count", nfall - b0, 6);
        chk(nrx - r0 == 6, "R5 sync byte count", nrx - r0, 6);
        for (int k = 0; k < 6; k++) begin
            chk(wid[(b0 + k) % 256] == 3, "R4 pulse width", wid[(b0 + k) % 256], 3);
            if (k > 0)
                chk(fall_cyc[(b0 + k) % 256] - fall_cyc[(b0 + k - 1) % 256] == 8, "R4 pulse period",
                    fall_cyc[(b0 + k) % 256] - fall_cyc[(b0 + k - 1) % 256], 8);
            chk(rxq[(r0 + k) % 256] == vec[k], "R5 R6 sync data", int'(rxq[(r0 + k) % 256]), int'(vec[k]));
        end
    endtask

    task automatic t_stray_ack();
        int r0 = nrx;
        db  = 8'h5A;
        dbp = ~^8'h5A;
        ack_n = 1'b0;
        step(4);
        ack_n = 1'b1;
        step(10);
        chk(nrx == r0, "R5 stray ack ignored", nrx - r0, 0);
        chk(ovalid === 1'b0, "R5 no output after stray ack", int'(ovalid), 0);
    endtask

    task automatic t_parity_async();
        int b0 = nfall, r0 = nrx, f1;
        fill(6, 8'h33);
        rdy = 1'b1;
        kick(1'b0, 6);
        peer(6, b0, 2, 1'b0);
        step(20);
        chk(irq === 1'b1, "R7 irq on bad parity", int'(irq), 1);
        chk(nrx - r0 == 2, "R7 bad byte dropped", nrx - r0, 2);
        chk(rxq[(r0 + 1) % 256] == vec[1], "R6 good bytes before error", int'(rxq[(r0 + 1) % 256]), int'(vec[1]));
        chk(nfall - b0 == 3, "R7 no request after error", nfall - b0, 3);
        f1 = nfall;
        kick(1'b0, 3);
        step(40);
        chk(nfall == f1, "R8 start ignored while irq", nfall - f1, 0);
        chk(irq === 1'b1, "R8 irq sticky", int'(irq), 1);
        chk(req_n === 1'b1, "R7 req stays high", int'(req_n), 1);
        irq_clr = 1'b1;
        step();
        irq_clr = 1'b0;
        step();
        chk(irq === 1'b0, "R8 irq cleared", int'(irq), 0);
    endtask

    task automatic t_parity_sync();
        int b0 = nfall, r0 = nrx, f1;
        fill(5, 8'hC4);
        wid_cfg = 8'd2;
        per_cfg = 8'd10;
        rdy = 1'b1;
        kick(1'b1, 5);
        peer(5, b0, 3, 1'b1);
        step(10);
        f1 = nfall;
        chk(irq === 1'b1, "R7 sync irq on bad parity", int'(irq), 1);
        chk(nrx - r0 == 3, "R7 sync bytes before error", nrx - r0, 3);
        step(60);
        chk(nfall == f1, "R7 sync pulses stop", nfall - f1, 0);
        irq_clr = 1'b1;
        step();
        irq_clr = 1'b0;
        step();
        chk(irq === 1'b0, "R8 irq cleared after sync error", int'(irq), 0);
    endtask

    task automatic t_flow();
        int b0 = nfall, r0 = nrx;
        fill(8, 8'h47);
        rdy = 1'b0;
        kick(1'b0, 8);
        fork
            peer(8, b0, -1, 1'b0);
            begin
                step(300);
                chk(nfall - b0 == 4, "R9 requests limited by buffer", nfall - b0, 4);
                chk(ovalid === 1'b1, "R10 valid held while stalled", int'(ovalid), 1);
                chk(odata == vec[0], "R10 data held while stalled", int'(odata), int'(vec[0]));
                rdy = 1'b1;
            end
        join
        step(30);
        chk(nrx - r0 == 8, "R9 all bytes after release", nrx - r0, 8);
        for (int i = 0; i < 8; i++)
            chk(rxq[(r0 + i) % 256] == vec[i], "R9 order after stall", int'(rxq[(r0 + i) % 256]), int'(vec[i]));
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(2);
        t_reset();
        t_async_basic();
        t_sync_timing();
        t_stray_ack();
        t_parity_async();
        t_parity_sync();
        t_flow();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule